// File: doc/BRIEF.md
# Prioritized System Interrupt Controller

This block gathers sixteen interrupt sources into one request line for a processor core. Eight sources come from external request pins, which are active low and asynchronous. The other eight are internal, active-high level lines from on-chip logic. The sources alternate in priority: pin 0 comes first, then internal line 0, then pin 1, then internal line 1, and so on down to internal line 7. Source index n is the n-th entry in that order, and index 0 is the most urgent.

Software uses a 32-bit register bus with separate read and write strobes. Through it, software programs a mask, picks edge or level capture for each external pin, acknowledges latched pin edges, and reads a vector that gives the most urgent source that is both pending and enabled. Nested masking is a software task: the handler rewrites the mask register.

Top module: `sic_top`

## Requirements
- R1: Source n (pin p is n = 2p, internal line p is n = 2p+1) sits at bit 31−n of the pending and mask registers. Bits 15:0 of both registers always read as zero.
- R2: After reset, the pending, mask and pin-mode registers all read zero and the request output is low.
- R3: `irq_o` is high exactly when at least one bit is set in both the pending and the mask registers.
- R4: The vector register (address 3) holds, in bits 31:26, the lowest index n whose pending and mask bits are both set. Bits 25:0 read as zero.
- R5: When no source is both pending and enabled, the vector register reads 15 in bits 31:26 (0x3C000000) and `irq_o` is low.
- R6: For a pin in edge mode, a high-to-low transition of its synchronized input sets its pending bit. The bit is set three clock edges after the pin changes, and it stays set after the pin returns high.
- R7: For a pin in level mode, its pending bit follows the inverse of the pin after the same three-edge synchronization delay.
- R8: For an edge-mode pin, writing a 1 to its pending bit at address 0 clears that bit. Writing a 0 leaves it unchanged.
- R9: Writes to address 0 have no effect on the pending bits of internal lines or of level-mode pins. An internal line's pending bit follows its input one clock edge later.
- R10: If a falling edge arrives in the same cycle as a write-one clear, the pending bit stays set.
- R11: The register map is: address 0 pending, address 1 mask, address 2 pin mode, address 3 vector (read-only). In the pin-mode register, bit p set to 1 selects edge mode for pin p, and bits 31:8 read as zero. Read data appears on `bus_rdata_o` one clock edge after the read strobe and holds until the next read.
- R12: Writes to mask bits 15:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr_i | input | 2 | Register word address |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| pin_n_i | input | 8 | External request pins, active low, asynchronous |
| lvl_i | input | 8 | Internal level requests, active high |
| irq_o | output | 1 | Interrupt request to the core |

## Verification
The bench lines up a synchronized pin edge with a write-one acknowledge in the same cycle. A design that gives the clear priority would drop the pending bit and lose that interrupt. It also writes ones to the pending bits of internal lines and level-mode pins. A design that let those writes through would briefly clear a bit that should track its input. Priority is tested while a pin and an internal line are pending together: an encoder with reversed order, or one that skipped the mask, would report the wrong six-bit code. The idle vector code and the synchronizer latency are both compared cycle by cycle against a behavioural model.

// File: rtl/sic_pkg.sv
package sic_pkg;
  localparam int unsigned REG_W = 32;
  localparam int unsigned VEC_W = 6;

  typedef enum logic [1:0] {
    RA_PEND = 2'd0,
    RA_MASK = 2'd1,
    RA_MODE = 2'd2,
    RA_VEC  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/sic_sync.sv
module sic_sync #(
  parameter int unsigned N_PINS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] pin_n_i,
  output logic [N_PINS-1:0] sync_n_o,
  output logic [N_PINS-1:0] fall_o
);
  logic [N_PINS-1:0] meta_q, meta_d;
  logic [N_PINS-1:0] stab_q, stab_d;
  logic [N_PINS-1:0] prev_q, prev_d;

  always_comb begin
    meta_d = pin_n_i;
    stab_d = meta_q;
    prev_d = stab_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '1;
      stab_q <= '1;
      prev_q <= '1;
    end else begin
      meta_q <= meta_d;
      stab_q <= stab_d;
      prev_q <= prev_d;
    end
  end

  assign sync_n_o = stab_q;
  assign fall_o   = prev_q & ~stab_q;
endmodule

// File: rtl/sic_pend.sv
module sic_pend #(
  parameter int unsigned N_PINS = 8,
  localparam int unsigned N_SRC = 2 * N_PINS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] sync_n_i,
  input  logic [N_PINS-1:0] fall_i,
  input  logic [N_PINS-1:0] lvl_i,
  input  logic [N_PINS-1:0] mode_i,
  input  logic              clr_en_i,
  input  logic [N_PINS-1:0] clr_i,
  output logic [N_SRC-1:0]  pend_o
);
  logic [N_SRC-1:0] pend_q, pend_d;

  for (genvar p = 0; p < N_PINS; p++) begin : g_src
    logic kill;
    assign kill = clr_en_i & clr_i[p];
    // edge mode: a new edge overrides an acknowledge in the same cycle
    assign pend_d[2*p]   = mode_i[p] ? (fall_i[p] | (pend_q[2*p] & ~kill))
                                     : ~sync_n_i[p];
    assign pend_d[2*p+1] = lvl_i[p];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/sic_prio.sv
module sic_prio #(
  parameter int unsigned N_SRC = 16,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] req_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  always_comb begin
    idx_o = IDX_W'(N_SRC - 1);
    for (int i = int'(N_SRC) - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/sic_top.sv
module sic_top
  import sic_pkg::*;
#(
  parameter int unsigned N_PINS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [REG_W-1:0]  bus_wdata_i,
  output logic [REG_W-1:0]  bus_rdata_o,
  input  logic [N_PINS-1:0] pin_n_i,
  input  logic [N_PINS-1:0] lvl_i,
  output logic              irq_o
);
  localparam int unsigned N_SRC  = 2 * N_PINS;
  localparam int unsigned IDX_W  = $clog2(N_SRC);
  localparam int unsigned LOW_HI = REG_W - N_SRC - 1;

  // reset: asserted at once, released after two clock edges
  logic rst_meta_q, rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_n      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n      <= rst_meta_q;
    end
  end

  logic [N_PINS-1:0] sync_n, fall, clr;
  logic [N_SRC-1:0]  pend, mask_q, mask_d;
  logic [N_PINS-1:0] mode_q, mode_d;
  logic [REG_W-1:0]  rdata_q, rdata_d;
  logic [IDX_W-1:0]  vec_idx;
  logic              any_req, clr_en, mask_en, mode_en, rd_en;
  logic              unused_wdata;

  reg_addr_e addr;
  assign addr = reg_addr_e'(bus_addr_i);

  assign clr_en  = bus_wr_i && addr == RA_PEND;
  assign mask_en = bus_wr_i && addr == RA_MASK;
  assign mode_en = bus_wr_i && addr == RA_MODE;
  assign rd_en   = bus_rd_i;
  assign unused_wdata = ^bus_wdata_i[LOW_HI:N_PINS];

  for (genvar p = 0; p < N_PINS; p++) begin : g_clr
    assign clr[p] = bus_wdata_i[REG_W-1-2*p];
  end

  sic_sync #(.N_PINS(N_PINS)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .pin_n_i  (pin_n_i),
    .sync_n_o (sync_n),
    .fall_o   (fall)
  );

  sic_pend #(.N_PINS(N_PINS)) u_pend (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .sync_n_i (sync_n),
    .fall_i   (fall),
    .lvl_i    (lvl_i),
    .mode_i   (mode_q),
    .clr_en_i (clr_en),
    .clr_i    (clr),
    .pend_o   (pend)
  );

  sic_prio #(.N_SRC(N_SRC)) u_prio (
    .req_i (pend & mask_q),
    .idx_o (vec_idx),
    .any_o (any_req)
  );

  // next state of the programmable registers
  always_comb begin
    mask_d = mask_q;
    mode_d = mode_q;
    if (mask_en) begin
      for (int n = 0; n < int'(N_SRC); n++) mask_d[n] = bus_wdata_i[REG_W-1-n];
    end
    if (mode_en) mode_d = bus_wdata_i[N_PINS-1:0];
  end

  // read mux
  always_comb begin
    rdata_d = rdata_q;
    if (rd_en) begin
      rdata_d = '0;
      unique case (addr)
        RA_PEND: for (int n = 0; n < int'(N_SRC); n++) rdata_d[REG_W-1-n] = pend[n];
        RA_MASK: for (int n = 0; n < int'(N_SRC); n++) rdata_d[REG_W-1-n] = mask_q[n];
        RA_MODE: rdata_d[N_PINS-1:0] = mode_q;
        RA_VEC:  rdata_d[REG_W-1 -: VEC_W] = VEC_W'(vec_idx);
        default: rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      mode_q  <= '0;
      rdata_q <= '0;
    end else begin
      mask_q  <= mask_d;
      mode_q  <= mode_d;
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata_o = rdata_q;
  assign irq_o       = any_req;
endmodule

// File: rtl/sic_checker.sv
module sic_checker #(
  parameter int unsigned N_PINS = 8,
  localparam int unsigned N_SRC = 2 * N_PINS,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input logic              clk_i,
  input logic              rst_n,
  input logic [1:0]        bus_addr_i,
  input logic              bus_wr_i,
  input logic              bus_rd_i,
  input logic [31:0]       bus_wdata_i,
  input logic [31:0]       bus_rdata_o,
  input logic [N_PINS-1:0] lvl_i,
  input logic              irq_o,
  input logic [N_SRC-1:0]  pend,
  input logic [N_SRC-1:0]  mask_q,
  input logic [N_PINS-1:0] mode_q,
  input logic [N_PINS-1:0] fall,
  input logic [IDX_W-1:0]  vec_idx
);
  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    p_edge_set_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
      (rst_n && mode_q[p] && fall[p]) |=> pend[2*p]);

    p_edge_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
      (rst_n && mode_q[p] && !fall[p] && !(bus_wr_i && bus_addr_i == 2'd0))
        |=> pend[2*p] == $past(pend[2*p]));

    p_edge_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
      (rst_n && mode_q[p] && !fall[p] && bus_wr_i && bus_addr_i == 2'd0
        && bus_wdata_i[31-2*p]) |=> !pend[2*p]);

    p_edge_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
      (rst_n && mode_q[p] && fall[p] && bus_wr_i && bus_addr_i == 2'd0)
        |=> pend[2*p]);

    p_lvl_track_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
      rst_n |=> pend[2*p+1] == $past(lvl_i[p]));
  end

  p_vec_none_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    ((pend & mask_q) == '0) |-> (vec_idx == IDX_W'(N_SRC - 1) && !irq_o));

  p_vec_valid_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq_o |-> (pend[vec_idx] && mask_q[vec_idx]));

  p_low_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rst_n && bus_rd_i && bus_addr_i != 2'd2) |=> bus_rdata_o[15:0] == 16'h0);

  p_rd_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rst_n && !bus_rd_i) |=> $stable(bus_rdata_o));
endmodule

bind sic_top sic_checker #(.N_PINS(N_PINS)) u_chk (
  .clk_i       (clk_i),
  .rst_n       (rst_n),
  .bus_addr_i  (bus_addr_i),
  .bus_wr_i    (bus_wr_i),
  .bus_rd_i    (bus_rd_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .lvl_i       (lvl_i),
  .irq_o       (irq_o),
  .pend        (pend),
  .mask_q      (mask_q),
  .mode_q      (mode_q),
  .fall        (fall),
  .vec_idx     (vec_idx)
);

// File: tb/sic_top_bench.sv
module sic_top_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  bus_addr_i = '0;
  logic        bus_wr_i = 1'b0;
  logic        bus_rd_i = 1'b0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic [7:0]  pin_n_i = 8'hFF;
  logic [7:0]  lvl_i = 8'h00;
  logic        irq_o;

  int n_checks = 0;
  int n_fail = 0;

  sic_top u_sic_top (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_addr_i(bus_addr_i),
    .bus_wr_i(bus_wr_i), .bus_rd_i(bus_rd_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .pin_n_i(pin_n_i), .lvl_i(lvl_i), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // ---------------- behavioural reference model ----------------
  bit [7:0]  m_s1, m_s2, m_s3;
  bit [15:0] m_pend, m_mask;
  bit [7:0]  m_mode;
  bit [31:0] m_rd;

  function automatic bit [31:0] to_reg(bit [15:0] v);
    bit [31:0] r = '0;
    for (int n = 0; n < 16; n++) r[31-n] = v[n];
    return r;
  endfunction

  function automatic int top_src(bit [15:0] v);
    for (int n = 0; n < 16; n++) if (v[n]) return n;
    return 15;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_s1 = '1; m_s2 = '1; m_s3 = '1;
      m_pend = '0; m_mask = '0; m_mode = '0; m_rd = '0;
    end else begin
      bit [15:0] np;
      bit [31:0] nr;
      np = m_pend;
      for (int p = 0; p < 8; p++) begin
        bit edge_seen;
        edge_seen = m_s3[p] && !m_s2[p];
        if (m_mode[p]) begin
          if (edge_seen) np[2*p] = 1'b1;
          else if (bus_wr_i && bus_addr_i == 2'd0 && bus_wdata_i[31-2*p]) np[2*p] = 1'b0;
        end else begin
          np[2*p] = !m_s2[p];
        end
        np[2*p+1] = lvl_i[p];
      end
      nr = m_rd;
      if (bus_rd_i) begin
        case (bus_addr_i)
          2'd0: nr = to_reg(m_pend);
          2'd1: nr = to_reg(m_mask);
          2'd2: nr = {24'h0, m_mode};
          default: nr = {6'(top_src(m_pend & m_mask)), 26'h0};
        endcase
      end
      if (bus_wr_i && bus_addr_i == 2'd1)
        for (int n = 0; n < 16; n++) m_mask[n] = bus_wdata_i[31-n];
      if (bus_wr_i && bus_addr_i == 2'd2) m_mode = bus_wdata_i[7:0];
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = pin_n_i;
      m_pend = np;
      m_rd = nr;
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk_i) begin
    if (rst_ni) begin
      chk("R3 irq vs model", 32'(irq_o), 32'(|(m_pend & m_mask)));
      chk("R11 rdata vs model", bus_rdata_o, m_rd);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc(bit w, bit r, bit [1:0] a, bit [31:0] d);
    @(posedge clk_i); #2;
    bus_wr_i = w; bus_rd_i = r; bus_addr_i = a; bus_wdata_i = d;
  endtask

  task automatic idle(int n);
    repeat (n) cyc(1'b0, 1'b0, 2'd0, 32'h0);
  endtask

  task automatic wr(bit [1:0] a, bit [31:0] d);
    cyc(1'b1, 1'b0, a, d);
    idle(1);
  endtask

  task automatic rd_chk(bit [1:0] a, bit [31:0] exp, string tag);
    cyc(1'b0, 1'b1, a, 32'h0);
    idle(1);
    @(negedge clk_i); #1;
    chk(tag, bus_rdata_o, exp);
  endtask

  task automatic irq_chk(bit exp, string tag);
    @(negedge clk_i); #1;
    chk(tag, 32'(irq_o), 32'(exp));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1'b1;
    idle(5);

    // R2 / R5 reset state
    irq_chk(1'b0, "R2 irq after reset");
    rd_chk(2'd0, 32'h0, "R2 pending reset");
    rd_chk(2'd1, 32'h0, "R2 mask reset");
    rd_chk(2'd2, 32'h0, "R2 mode reset");
    rd_chk(2'd3, 32'h3C00_0000, "R5 idle vector");

    // internal line 0 = source 1 = bit 30
    lvl_i[0] = 1'b1;
    idle(3);
    rd_chk(2'd0, 32'h4000_0000, "R1 internal line bit position");
    irq_chk(1'b0, "R3 masked source gives no irq");
    wr(2'd1, 32'hFFFF_0000);
    irq_chk(1'b1, "R3 enabled pending raises irq");
    rd_chk(2'd3, 32'h0400_0000, "R4 vector for source 1");
    wr(2'd0, 32'h4000_0000);
    rd_chk(2'd0, 32'h4000_0000, "R9 write ignored on internal line");

    // pin 2 level mode = source 4 = bit 27
    pin_n_i[2] = 1'b0;
    idle(4);
    rd_chk(2'd0, 32'h4800_0000, "R7 level pin follows input");
    rd_chk(2'd3, 32'h0400_0000, "R4 higher priority wins");
    lvl_i[0] = 1'b0;
    idle(3);
    rd_chk(2'd3, 32'h1000_0000, "R4 vector for source 4");
    wr(2'd0, 32'h0800_0000);
    rd_chk(2'd0, 32'h0800_0000, "R9 write ignored on level pin");
    pin_n_i[2] = 1'b1;
    idle(4);
    rd_chk(2'd0, 32'h0, "R7 level pin released");
    rd_chk(2'd3, 32'h3C00_0000, "R5 vector when nothing pending");
    irq_chk(1'b0, "R5 irq low when nothing pending");

    // mask low bits and mode register layout
    wr(2'd1, 32'h0000_FFFF);
    rd_chk(2'd1, 32'h0, "R12 low mask bits ignored");
    wr(2'd2, 32'hFFFF_FF01);
    rd_chk(2'd2, 32'h0000_0001, "R11 mode register layout");
    wr(2'd1, 32'h8000_0000);

    // pin 0 edge mode = source 0 = bit 31
    pin_n_i[0] = 1'b0;
    idle(2);
    pin_n_i[0] = 1'b1;
    idle(4);
    rd_chk(2'd0, 32'h8000_0000, "R6 edge latched after pin released");
    rd_chk(2'd3, 32'h0000_0000, "R4 vector for source 0");
    irq_chk(1'b1, "R3 irq from edge source");
    wr(2'd0, 32'h0000_0000);
    rd_chk(2'd0, 32'h8000_0000, "R8 zero write keeps edge bit");
    wr(2'd0, 32'h8000_0000);
    rd_chk(2'd0, 32'h0, "R8 one write clears edge bit");
    irq_chk(1'b0, "R3 irq drops after acknowledge");

    // R10: re-latch, then a clear coincides with a fresh edge
    pin_n_i[0] = 1'b0;
    idle(2);
    pin_n_i[0] = 1'b1;
    idle(4);
    idle(1);
    pin_n_i[0] = 1'b0;                  // changes after edge P0
    idle(1);                            // P1: first stage
    cyc(1'b1, 1'b0, 2'd0, 32'h8000_0000); // captured at P3, same edge as the set
    idle(1);
    pin_n_i[0] = 1'b1;
    idle(3);
    rd_chk(2'd0, 32'h8000_0000, "R10 edge beats simultaneous clear");
    wr(2'd0, 32'h8000_0000);
    rd_chk(2'd0, 32'h0, "R8 later clear succeeds");

    idle(3);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule